// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier (radix 2)

This block multiplies two N-bit two's complement numbers over several clock cycles and returns a 2N-bit signed product. A pulse on `start` while the block is idle captures both operands. The block then runs one recoding step per cycle. Each step looks at the lowest bit still held in the multiplier part of a working register, together with one extra bit kept to its right. From that pair it decides whether to subtract the multiplicand from the upper half, add it, or leave the upper half alone. The whole register then moves one place to the right, and the sign is copied into the top bit.

Runs of ones in the multiplier therefore cost one subtraction at their low end and one addition just past their high end. Negative multipliers and negative multiplicands need no pre- or post-correction. The accumulator adder is one bit wider than the operands, so the most negative multiplicand gives the right result. After N steps the product sits in the register, `done` pulses for one cycle, and the product stays on the output until the next accepted start.

Top module: `booth_mul_r2`

## Requirements
- R1: After reset, `busy`, `done` and `product` are all zero.
- R2: A `start` sampled high while `busy` is low is accepted. From the next cycle `busy` is high, the lower N bits of `product` equal the multiplier and the upper N bits are zero.
- R3: For every pair of N-bit two's complement operands, including the most negative value on either side, the `product` shown with `done` equals their signed product as a 2N-bit two's complement value.
- R4: `done` is high in the cycle that follows the N-th clock edge after the edge that accepted `start`. In that same cycle `busy` is low, so `busy` is high for exactly N cycles.
- R5: `done` is high for one cycle only per accepted operation.
- R6: A `start` sampled while `busy` is high is ignored. The running operation finishes with its original operands and its original result.
- R7: While the block is idle and `start` is low, `product` does not change.
- R8: On every step, the bit to the right of the multiplier field takes the multiplier field's previous lowest bit. In other words, the register shifts one place per step.
- R9: The step operation follows the bit pair (lowest multiplier bit, bit to its right). The pair 1,0 subtracts the multiplicand, 0,1 adds it, and 0,0 or 1,1 changes nothing before the shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| multiplicand | input | N | Signed multiplicand, captured on an accepted start |
| multiplier | input | N | Signed multiplier, captured on an accepted start |
| busy | output | 1 | High while recoding steps are in progress |
| done | output | 1 | One-cycle pulse when the product is valid |
| product | output | 2N | Signed product; valid from `done` until the next accepted start |

## Verification
The bench is built with N = 6 and runs every one of the 4096 operand pairs. The sweep therefore covers every multiplier bit pattern the recoder can meet: long runs of ones, alternating bits, a single set bit and all ones. It also covers every sign combination, so an add/subtract swap, a wrong pair decode or a missing guard bit shows up as a wrong product. On the most negative multiplicand the guard-bit error is isolated from the others. Every operation is timed from the accepted start to `done`, and `done` is checked to fall after one cycle. Directed runs pulse `start` in the middle of an operation with different operands, which separates a correct ignore from a restart. Idle periods with changing inputs show whether the product holds.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_ADD  = 2'd1,
    STEP_SUB  = 2'd2
  } step_op_e;

  // Bit pair decode: current multiplier bit and the bit to its right.
  function automatic step_op_e pair_to_op(input logic cur_bit, input logic right_bit);
    step_op_e op;
    unique case ({cur_bit, right_bit})
      2'b10:   op = STEP_SUB;
      2'b01:   op = STEP_ADD;
      default: op = STEP_HOLD;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic     cur_bit,
  input  logic     right_bit,
  output step_op_e op
);

  always_comb op = pair_to_op(cur_bit, right_bit);

endmodule

// File: rtl/booth_step.sv
module booth_step
  import booth_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] acc,
  input  logic [N-1:0] mq,
  input  logic         right_bit,
  input  logic [N-1:0] mcand,
  input  step_op_e     op,
  output logic [N-1:0] acc_next,
  output logic [N-1:0] mq_next,
  output logic         right_next
);

  localparam int GW = N + 1;

  function automatic logic [GW-1:0] widen(input logic [N-1:0] v);
    return {v[N-1], v};
  endfunction

  function automatic logic [GW-1:0] combine(input logic [GW-1:0] a,
                                            input logic [GW-1:0] m,
                                            input step_op_e      sel);
    logic [GW-1:0] r;
    unique case (sel)
      STEP_ADD: r = a + m;
      STEP_SUB: r = a + (~m) + GW'(1);
      default:  r = a;
    endcase
    return r;
  endfunction

  logic [GW-1:0] guard_sum;

  always_comb begin
    guard_sum  = combine(widen(acc), widen(mcand), op);
    acc_next   = guard_sum[GW-1:1];
    mq_next    = {guard_sum[0], mq[N-1:1]};
    right_next = mq[0];
  end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic load,
  output logic step
);

  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(N - 1);

  logic [CW-1:0] cnt_q;
  logic          last_step;

  always_comb begin
    load      = start && !busy;
    step      = busy;
    last_step = busy && (cnt_q == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt_q <= '0;
    end else begin
      done <= last_step;
      if (load) begin
        busy  <= 1'b1;
        cnt_q <= '0;
      end else if (busy) begin
        if (last_step) busy <= 1'b0;
        else           cnt_q <= cnt_q + CW'(1);
      end
    end
  end

endmodule

// File: rtl/booth_mul_r2.sv
module booth_mul_r2
  import booth_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   multiplicand,
  input  logic [N-1:0]   multiplier,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);

  logic [N-1:0] acc_q, mq_q, mcand_q;
  logic         right_q;
  logic [N-1:0] acc_n, mq_n;
  logic         right_n;
  logic         load_ev, step_ev;
  step_op_e     step_op;

  booth_ctrl #(.N(N)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .load  (load_ev),
    .step  (step_ev)
  );

  booth_recode u_rec (
    .cur_bit   (mq_q[0]),
    .right_bit (right_q),
    .op        (step_op)
  );

  booth_step #(.N(N)) u_step (
    .acc        (acc_q),
    .mq         (mq_q),
    .right_bit  (right_q),
    .mcand      (mcand_q),
    .op         (step_op),
    .acc_next   (acc_n),
    .mq_next    (mq_n),
    .right_next (right_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      mq_q    <= '0;
      right_q <= 1'b0;
      mcand_q <= '0;
    end else if (load_ev) begin
      acc_q   <= '0;
      mq_q    <= multiplier;
      right_q <= 1'b0;
      mcand_q <= multiplicand;
    end else if (step_ev) begin
      acc_q   <= acc_n;
      mq_q    <= mq_n;
      right_q <= right_n;
    end
  end

  assign product = {acc_q, mq_q};

endmodule

// File: rtl/booth_mul_r2_chk.sv
module booth_mul_r2_chk
  import booth_pkg::*;
#(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [N-1:0]   multiplier,
  input logic [2*N-1:0] product,
  input logic [N-1:0]   mq_q,
  input logic [N-1:0]   acc_q,
  input logic [N-1:0]   mcand_q,
  input logic           right_q,
  input step_op_e       step_op
);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && product[N-1:0] == $past(multiplier) && product[2*N-1:N] == '0));

  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_busy_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_ignore_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mcand_q));

  p_hold_product_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));

  p_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (right_q == $past(mq_q[0])));

  p_hold_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (mq_q[0] == right_q)) |=> (acc_q[N-2:0] == $past(acc_q[N-1:1])));

  p_op_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (step_op != STEP_SUB || (mq_q[0] && !right_q)));

endmodule

bind booth_mul_r2 booth_mul_r2_chk #(.N(N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .multiplier (multiplier),
  .product    (product),
  .mq_q       (mq_q),
  .acc_q      (acc_q),
  .mcand_q    (mcand_q),
  .right_q    (right_q),
  .step_op    (step_op)
);

// File: tb/sim_booth_mul_r2.sv
`timescale 1ns/1ps
module sim_booth_mul_r2;

  localparam int W  = 6;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  multiplicand = '0;
  logic [W-1:0]  multiplier = '0;
  logic          busy, done;
  logic [PW-1:0] product;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  booth_mul_r2 #(.N(W)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .busy         (busy),
    .done         (done),
    .product      (product)
  );

  function automatic int as_signed(input logic [W-1:0] v);
    return v[W-1] ? int'(v) - (1 << W) : int'(v);
  endfunction

  function automatic logic [PW-1:0] expect_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    int p;
    p = as_signed(a) * as_signed(b);
    return PW'(p);
  endfunction

  task automatic check(input string req, input logic [PW-1:0] got, input logic [PW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke);
    int k;
    logic [PW-1:0] exp;
    exp = expect_mul(a, b);
    @(negedge clk);
    multiplicand = a;
    multiplier   = b;
    start        = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy", PW'(busy), PW'(1));
    check("R2 load", product, {{W{1'b0}}, b});
    k = 1;
    while (!done && k < 40) begin
      @(negedge clk);
      k++;
      if (poke && k == 3) begin
        start        = 1'b1;
        multiplicand = ~a;
        multiplier   = b ^ {W{1'b1}};
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    check("R4 latency", PW'(k), PW'(W + 1));
    check("R4 busy low at done", PW'(busy), PW'(0));
    if (poke) check("R6 ignored start", product, exp);
    else      check("R3 product", product, exp);
    @(negedge clk);
    check("R5 done pulse", PW'(done), PW'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [PW-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy", PW'(busy), PW'(0));
    check("R1 done", PW'(done), PW'(0));
    check("R1 product", product, '0);

    // R9 recoding corners: all ones, alternating, single bit, most negative
    run(6'b100000, 6'b100000, 1'b0);
    run(6'b100000, 6'b111111, 1'b0);
    run(6'b011111, 6'b101010, 1'b0);
    run(6'b000011, 6'b010101, 1'b0);
    run(6'b111101, 6'b000001, 1'b0);

    // R6: start pulsed mid-operation with other operands
    run(6'b010110, 6'b110011, 1'b1);
    run(6'b100000, 6'b011011, 1'b1);

    // R7: product holds while idle even as inputs move
    held = product;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      multiplicand = W'(i * 7);
      multiplier   = W'(i * 13 + 1);
      check("R7 hold", product, held);
    end

    // R3, R8, R9: exhaustive sweep
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        run(W'(a), W'(b), 1'b0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule